// File: doc/BRIEF.md
# Character Display Host Write Port

This block is the host side of an eight-digit dot-matrix character display. A host drives an 8-bit data bus, a 5-bit address, an active-low chip enable, an active-low write strobe and an active-low flash select. On each rising edge of the write strobe taken while chip enable is low, the block stores part of the data bus in one of five storage areas. The flash select and the top two address bits choose the area: per-digit flash enables, the custom-glyph selector, the custom-glyph row RAM, the character cells, or the control word.

The host strobes are asynchronous to the display clock. They pass through a synchronizer, and a one-cycle write pulse is formed from the synchronized write-strobe edge. A refresh engine reads the stored state through registered ports. One port reads a character cell and reports whether the cell holds an ASCII code or a custom-glyph index. Another reads a custom-glyph row. Flash enables, control word and glyph selector are presented directly as registers. After a synchronous reset, host activity is ignored for a fixed number of display clocks, and a busy flag is raised for that period.

Top module: `disp_host_if`

## Requirements
- R1: While reset is applied and on the first clock after it, every character cell reads 0x20, all flash enables are 0, the control word is 0x00 and busy is 1.
- R2: After reset falls, busy stays 1 for exactly LOCK_CYC (3) clocks and then stays 0. Strobe activity that starts while busy is high changes no storage.
- R3: A store happens once per rising edge of host_wr_n, and only if host_ce_n is low at that edge. A rising edge with host_ce_n high changes nothing.
- R4: When host_fl_n is 0, the flash area is written whatever host_addr[4:3] is. host_data[0] is stored as the flash enable of digit host_addr[2:0], which appears as bit host_addr[2:0] of flash_mask.
- R5: When host_fl_n is 1 and host_addr[4:3] is 2'b00, host_data[3:0] is stored in udc_sel. host_addr[2:0] is ignored.
- R6: When host_fl_n is 1 and host_addr[4:3] is 2'b01, host_data[4:0] is stored as the row pattern at glyph udc_sel, row host_addr[2:0]. The row port returns the row addressed by {udc_rd_char, udc_rd_row} one clock after the address is presented.
- R7: When host_fl_n is 1 and host_addr[4:3] is 2'b11, host_data[7:0] is stored in character cell host_addr[2:0]. The cell port returns cell char_rd_addr one clock after the address is presented.
- R8: When host_fl_n is 1 and host_addr[4:3] is 2'b10, host_data[7:0] is stored as ctrl_word.
- R9: If a character cell is written in the same clock in which the cell port reads it, the cell port returns the old contents in that clock and the new contents one clock later.
- R10: When bit 7 of the cell being read is 1, char_rd_is_udc is 1 and char_rd_udc_idx is bits 3:0 of the cell. When bit 7 is 0, char_rd_is_udc is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous active-high reset |
| host_fl_n | input | 1 | Flash-area select, active low |
| host_ce_n | input | 1 | Chip enable, active low |
| host_wr_n | input | 1 | Write strobe; stores on rising edge |
| host_addr | input | 5 | Area select [4:3] and digit/row index [2:0] |
| host_data | input | 8 | Write data |
| busy | output | 1 | Post-reset lockout in progress |
| char_rd_addr | input | 3 | Refresh read address of a character cell |
| char_rd_data | output | 8 | Registered character cell contents |
| char_rd_is_udc | output | 1 | Cell holds a custom-glyph index |
| char_rd_udc_idx | output | 4 | Custom-glyph index from the cell |
| udc_rd_char | input | 4 | Refresh read glyph index |
| udc_rd_row | input | 3 | Refresh read row |
| udc_rd_data | output | 5 | Registered glyph row pattern |
| flash_mask | output | 8 | Per-digit flash enables |
| ctrl_word | output | 8 | Control word |
| udc_sel | output | 4 | Custom-glyph selector for host row writes |

## Verification
Two events can fall in the same clock. A host store to a character cell can coincide with a refresh read of that cell. The end of the reset lockout can coincide with a write strobe that is already in progress. The bench parks the cell read address on the digit being written and samples the read port in the clock of the store and in the clock after it, expecting the old value and then the new one. It also holds the strobes low across the release of reset and lets the write edge arrive while busy is still high. It then expects busy to fall on the third clock and the targeted cell to still read blank.

// File: rtl/disp_host_pkg.sv
package disp_host_pkg;

  localparam logic [7:0] BLANK_CODE = 8'h20;

  typedef enum logic [2:0] {
    AREA_FLASH,
    AREA_GLYPH_SEL,
    AREA_GLYPH_ROW,
    AREA_CELL,
    AREA_CTRL
  } area_e;

  // Area decode: the flash strobe overrides the two area bits.
  function automatic area_e decode_area(input logic fl_n, input logic [1:0] hi);
    area_e a;
    if (!fl_n) a = AREA_FLASH;
    else begin
      case (hi)
        2'b00:   a = AREA_GLYPH_SEL;
        2'b01:   a = AREA_GLYPH_ROW;
        2'b11:   a = AREA_CELL;
        default: a = AREA_CTRL;
      endcase
    end
    return a;
  endfunction

endpackage

// File: rtl/disp_host_sync.sv
module disp_host_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic wr_n_async,
  input  logic ce_n_async,
  output logic wr_pulse
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] wr_sr;
  logic [LEN-1:0] ce_sr;

  genvar g;
  generate
    for (g = 0; g < LEN; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst || hold) begin
          wr_sr[g] <= 1'b1;
          ce_sr[g] <= 1'b1;
        end else if (g == 0) begin
          wr_sr[g] <= wr_n_async;
          ce_sr[g] <= ce_n_async;
        end else begin
          wr_sr[g] <= wr_sr[g-1];
          ce_sr[g] <= ce_sr[g-1];
        end
      end
    end
  endgenerate

  // Rising strobe edge, qualified by enable as seen before that edge.
  assign wr_pulse = wr_sr[STAGES-1] & ~wr_sr[STAGES] & ~ce_sr[STAGES];

endmodule

// File: rtl/disp_host_lockout.sv
module disp_host_lockout #(
  parameter int LOCK_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  output logic busy
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] START = CW'(LOCK_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= START;
      busy <= 1'b1;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
      busy <= (cnt != CW'(1));
    end else begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/disp_host_regs.sv
module disp_host_regs
  import disp_host_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter int DW     = 8,
  parameter int IDX_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_cell,
  input  logic                       we_flash,
  input  logic                       we_ctrl,
  input  logic                       we_sel,
  input  logic [$clog2(DIGITS)-1:0]  wdig,
  input  logic [DW-1:0]              wdata,
  input  logic [$clog2(DIGITS)-1:0]  rd_dig,
  output logic [DW-1:0]              cell_q,
  output logic                       cell_is_udc,
  output logic [IDX_W-1:0]           cell_idx,
  output logic [DIGITS-1:0]          flash_q,
  output logic [DW-1:0]              ctrl_q,
  output logic [IDX_W-1:0]           sel_q
);
  logic [DW-1:0] cells [DIGITS];
  logic [DW-1:0] rd_word;

  genvar d;
  generate
    for (d = 0; d < DIGITS; d++) begin : g_digit
      always_ff @(posedge clk) begin
        if (rst) begin
          cells[d]   <= BLANK_CODE;
          flash_q[d] <= 1'b0;
        end else begin
          if (we_cell && wdig == d) cells[d] <= wdata;
          if (we_flash && wdig == d) flash_q[d] <= wdata[0];
        end
      end
    end
  endgenerate

  always_comb rd_word = cells[rd_dig];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      sel_q       <= '0;
      cell_q      <= BLANK_CODE;
      cell_is_udc <= 1'b0;
      cell_idx    <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= wdata;
      if (we_sel)  sel_q  <= wdata[IDX_W-1:0];
      cell_q      <= rd_word;
      cell_is_udc <= rd_word[DW-1];
      cell_idx    <= rd_word[DW-1] ? rd_word[IDX_W-1:0] : '0;
    end
  end

endmodule

// File: rtl/disp_host_glyph_ram.sv
module disp_host_glyph_ram #(
  parameter int AW = 7,
  parameter int W  = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/disp_host_if.sv
module disp_host_if
  import disp_host_pkg::*;
#(
  parameter int DIGITS      = 8,
  parameter int DW          = 8,
  parameter int GLYPHS      = 16,
  parameter int GLYPH_ROWS  = 8,
  parameter int GLYPH_COLS  = 5,
  parameter int LOCK_CYC    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int DIG_AW = $clog2(DIGITS),
  localparam int IDX_W  = $clog2(GLYPHS),
  localparam int ROW_AW = $clog2(GLYPH_ROWS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_fl_n,
  input  logic                  host_ce_n,
  input  logic                  host_wr_n,
  input  logic [4:0]            host_addr,
  input  logic [DW-1:0]         host_data,
  output logic                  busy,
  input  logic [DIG_AW-1:0]     char_rd_addr,
  output logic [DW-1:0]         char_rd_data,
  output logic                  char_rd_is_udc,
  output logic [IDX_W-1:0]      char_rd_udc_idx,
  input  logic [IDX_W-1:0]      udc_rd_char,
  input  logic [ROW_AW-1:0]     udc_rd_row,
  output logic [GLYPH_COLS-1:0] udc_rd_data,
  output logic [DIGITS-1:0]     flash_mask,
  output logic [DW-1:0]         ctrl_word,
  output logic [IDX_W-1:0]      udc_sel
);
  localparam int RAM_AW = IDX_W + ROW_AW;

  logic  wr_pulse;
  logic  wr_ok;
  area_e area;

  disp_host_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk  (clk),
    .rst  (rst),
    .busy (busy)
  );

  disp_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .hold       (busy),
    .wr_n_async (host_wr_n),
    .ce_n_async (host_ce_n),
    .wr_pulse   (wr_pulse)
  );

  always_comb begin
    area  = decode_area(host_fl_n, host_addr[4:3]);
    wr_ok = wr_pulse & ~busy;
  end

  disp_host_regs #(.DIGITS(DIGITS), .DW(DW), .IDX_W(IDX_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .we_cell     (wr_ok && area == AREA_CELL),
    .we_flash    (wr_ok && area == AREA_FLASH),
    .we_ctrl     (wr_ok && area == AREA_CTRL),
    .we_sel      (wr_ok && area == AREA_GLYPH_SEL),
    .wdig        (host_addr[DIG_AW-1:0]),
    .wdata       (host_data),
    .rd_dig      (char_rd_addr),
    .cell_q      (char_rd_data),
    .cell_is_udc (char_rd_is_udc),
    .cell_idx    (char_rd_udc_idx),
    .flash_q     (flash_mask),
    .ctrl_q      (ctrl_word),
    .sel_q       (udc_sel)
  );

  disp_host_glyph_ram #(.AW(RAM_AW), .W(GLYPH_COLS)) u_ram (
    .clk   (clk),
    .we    (wr_ok && area == AREA_GLYPH_ROW),
    .waddr ({udc_sel, host_addr[ROW_AW-1:0]}),
    .wdata (host_data[GLYPH_COLS-1:0]),
    .raddr ({udc_rd_char, udc_rd_row}),
    .rdata (udc_rd_data)
  );

endmodule

// File: rtl/disp_host_if_chk.sv
module disp_host_if_chk #(
  parameter int DIGITS = 8,
  parameter int DW     = 8,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              host_fl_n,
  input logic [4:0]        host_addr,
  input logic [DW-1:0]     host_data,
  input logic              busy,
  input logic              wr_pulse,
  input logic [DIGITS-1:0] flash_mask,
  input logic [DW-1:0]     ctrl_word,
  input logic [IDX_W-1:0]  udc_sel
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: reset state is visible at the first edge after release
  always @(posedge clk) begin
    if (rst_q === 1'b1 && rst === 1'b0)
      assert_reset_state_R1: assert (busy && ctrl_word == '0 && flash_mask == '0);
  end

  assert_busy_no_return_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

  assert_no_pulse_in_lockout_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !wr_pulse);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);

  assert_flash_store_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_pulse && !host_fl_n) |=>
      flash_mask[$past(host_addr[2:0])] == $past(host_data[0]));

  assert_sel_store_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_pulse && host_fl_n && host_addr[4:3] == 2'b00) |=>
      udc_sel == $past(host_data[IDX_W-1:0]));

  assert_ctrl_store_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_pulse && host_fl_n && host_addr[4:3] == 2'b10) |=>
      ctrl_word == $past(host_data));

  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_pulse |=> $stable(ctrl_word) && $stable(flash_mask) && $stable(udc_sel));

endmodule

bind disp_host_if disp_host_if_chk #(.DIGITS(DIGITS), .DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_fl_n  (host_fl_n),
  .host_addr  (host_addr),
  .host_data  (host_data),
  .busy       (busy),
  .wr_pulse   (wr_pulse),
  .flash_mask (flash_mask),
  .ctrl_word  (ctrl_word),
  .udc_sel    (udc_sel)
);

// File: tb/disp_host_if_tb.sv
`timescale 1ns/1ps
module disp_host_if_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_fl_n = 1'b1, host_ce_n = 1'b1, host_wr_n = 1'b1;
  logic [4:0] host_addr = '0;
  logic [7:0] host_data = '0;
  logic busy;
  logic [2:0] char_rd_addr = '0;
  logic [7:0] char_rd_data;
  logic char_rd_is_udc;
  logic [3:0] char_rd_udc_idx;
  logic [3:0] udc_rd_char = '0;
  logic [2:0] udc_rd_row = '0;
  logic [4:0] udc_rd_data;
  logic [7:0] flash_mask, ctrl_word;
  logic [3:0] udc_sel;

  always #2 clk = ~clk;

  disp_host_if u_dut (.*);

  int checks = 0, errors = 0;
  int pushed = 0, done = 0;

  typedef struct { int kind; int idx; int exp; string tag; } item_t;
  item_t sbq[$];

  logic [7:0] m_cell [8];
  logic [7:0] m_flash, m_ctrl;
  logic [3:0] m_sel;
  logic [4:0] m_row [128];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(int kind, int idx, int exp, string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    pushed++;
  endtask

  task automatic drain();
    wait (done == pushed);
  endtask

  // Monitor: present read addresses, sample one clock later
  initial begin
    forever begin
      item_t it;
      wait (sbq.size() > 0);
      it = sbq.pop_front();
      @(negedge clk);
      if (it.kind == 0 || it.kind == 6) char_rd_addr = it.idx[2:0];
      if (it.kind == 4) begin
        udc_rd_char = it.idx[6:3];
        udc_rd_row  = it.idx[2:0];
      end
      @(negedge clk);
      case (it.kind)
        0: chk(it.tag, char_rd_data, it.exp);
        1: chk(it.tag, flash_mask[it.idx], it.exp);
        2: chk(it.tag, ctrl_word, it.exp);
        3: chk(it.tag, udc_sel, it.exp);
        4: chk(it.tag, udc_rd_data, it.exp);
        5: chk(it.tag, busy, it.exp);
        default: chk(it.tag, {char_rd_is_udc, char_rd_udc_idx}, it.exp);
      endcase
      done++;
    end
  end

  task automatic host_write(bit fl_n, logic [4:0] addr, logic [7:0] data, bit ce_on);
    @(negedge clk);
    host_fl_n = fl_n; host_addr = addr; host_data = data; host_ce_n = !ce_on;
    @(negedge clk); host_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    host_ce_n = 1'b1;
    @(negedge clk);
    if (ce_on) begin
      if (!fl_n) m_flash[addr[2:0]] = data[0];
      else case (addr[4:3])
        2'b00: m_sel = data[3:0];
        2'b01: m_row[{m_sel, addr[2:0]}] = data[4:0];
        2'b11: m_cell[addr[2:0]] = data;
        default: m_ctrl = data;
      endcase
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_cell[i] = 8'h20;
    m_flash = '0; m_ctrl = '0; m_sel = '0;
    repeat (4) @(negedge clk);
    // R1: reset state while reset held
    chk("R1 busy in reset", busy, 1);
    chk("R1 ctrl in reset", ctrl_word, 0);
    // R2: strobe already active across release
    host_fl_n = 1'b1; host_addr = 5'b11_000; host_data = 8'h41;
    host_ce_n = 1'b0; host_wr_n = 1'b0;
    rst = 1'b0;                       // R0
    @(negedge clk);                   // R1 edge done
    @(negedge clk);                   // after second edge
    chk("R2 busy after 2 clocks", busy, 1);
    host_wr_n = 1'b1;
    @(negedge clk);
    chk("R2 busy low after 3 clocks", busy, 0);
    repeat (6) @(negedge clk);
    host_ce_n = 1'b1;
    push(0, 0, 8'h20, "R2 lockout write ignored");
    for (int i = 1; i < 8; i++) push(0, i, 8'h20, "R1 cell blank");
    push(2, 0, 0, "R1 ctrl zero");
    push(1, 3, 0, "R1 flash zero");
    push(5, 0, 0, "R2 busy stays low");
    drain();

    // R7 cell writes with several patterns
    host_write(1, 5'b11_000, 8'h48, 1);
    host_write(1, 5'b11_111, 8'h7e, 1);
    host_write(1, 5'b11_011, 8'h00, 1);
    push(0, 0, m_cell[0], "R7 cell 0");
    push(0, 7, m_cell[7], "R7 cell 7");
    push(0, 3, m_cell[3], "R7 cell 3");
    drain();

    // R3 strobe with enable high
    host_write(1, 5'b11_000, 8'h55, 0);
    push(0, 0, m_cell[0], "R3 write with CE high ignored");
    drain();

    // R4 flash, under every area bit pattern
    host_write(0, 5'b00_001, 8'h01, 1);
    host_write(0, 5'b11_110, 8'hff, 1);
    host_write(0, 5'b10_100, 8'h03, 1);
    host_write(0, 5'b01_110, 8'hfe, 1);
    push(1, 1, m_flash[1], "R4 flash digit 1");
    push(1, 6, m_flash[6], "R4 flash digit 6 cleared");
    push(1, 4, m_flash[4], "R4 flash digit 4");
    push(0, 6, m_cell[6], "R4 cell untouched");
    push(2, 0, m_ctrl, "R4 ctrl untouched");
    drain();

    // R8 control word
    host_write(1, 5'b10_101, 8'hc3, 1);
    push(2, 0, m_ctrl, "R8 ctrl");
    drain();

    // R5 selector and R6 rows
    host_write(1, 5'b00_111, 8'hf9, 1);
    push(3, 0, m_sel, "R5 selector");
    host_write(1, 5'b01_000, 8'h15, 1);
    host_write(1, 5'b01_110, 8'hea, 1);
    host_write(1, 5'b00_010, 8'h02, 1);
    host_write(1, 5'b01_000, 8'h0a, 1);
    push(3, 0, m_sel, "R5 selector rewrite");
    push(4, {4'd9, 3'd0}, m_row[{4'd9, 3'd0}], "R6 glyph 9 row 0");
    push(4, {4'd9, 3'd6}, m_row[{4'd9, 3'd6}], "R6 glyph 9 row 6");
    push(4, {4'd2, 3'd0}, m_row[{4'd2, 3'd0}], "R6 glyph 2 row 0");
    drain();

    // R10 decode
    host_write(1, 5'b11_010, 8'h8b, 1);
    host_write(1, 5'b11_100, 8'h41, 1);
    push(6, 2, 5'h1b, "R10 custom index");
    push(6, 4, 5'h00, "R10 ascii cell");
    drain();

    // R9 read of the cell being written
    @(negedge clk);
    char_rd_addr = 3'd5;
    host_fl_n = 1'b1; host_addr = 5'b11_101; host_data = 8'h3c; host_ce_n = 1'b0;
    @(negedge clk); host_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 old value in store clock", char_rd_data, 8'h20);
    @(negedge clk);
    chk("R9 new value next clock", char_rd_data, 8'h3c);
    host_ce_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule